// File: doc/BRIEF.md
# Source-Sticky Write Buffer Allocator

This block sits in front of a command queue. It chooses one of eight write data buffers for every incoming WRITE command and reports that choice to the queue. The normal choice is the lowest-numbered buffer that holds no outstanding command. There is one exception. When a WRITE comes from the same source as the previously accepted WRITE, and that earlier write's buffer still has work outstanding, the new write is sent into the same buffer. This keeps the source's data in one place.

Each buffer holds a count of outstanding commands and the source that owns it. An allocation raises the count. A completion pulse, which carries a buffer index, lowers it. When the count reaches zero the buffer returns to the free pool and its owner is cleared. Data leaves a buffer in the order it was written. The grant therefore carries a flag that tells the queue the new write shares a buffer with commands already queued, and the queue must keep those commands in arrival order. When no legal buffer exists, the request is held off with ready low.

Top module: `wba_alloc`

## Requirements
- R1: After synchronous reset, `buf_busy` is all zeros and `grant_valid` is low.
- R2: A write that is not a sticky reuse is given the lowest-numbered buffer whose `buf_busy` bit is 0, and `grant_shared` is 0.
- R3: A write whose source equals the owner of the previously accepted write's buffer, while that buffer is still busy, is given that buffer with `grant_shared` = 1, even when lower-numbered buffers are free.
- R4: A write from a source that wrote earlier, but not in the immediately preceding accepted write, does not reuse that earlier buffer; R2 applies to it.
- R5: `grant_valid` pulses for exactly one cycle, in the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge). In that cycle `grant_buf` holds the 3-bit buffer index.
- R6: A sticky write whose target buffer already holds 2**CNT_W-1 outstanding commands (15 by default) is stalled with `req_ready` low. This holds even if other buffers are free. The stall lasts until a completion for that buffer.
- R7: When every buffer is busy and the sticky rule does not apply, `req_ready` is low and no grant is issued.
- R8: A `done_valid` pulse with index `done_buf` removes one outstanding command from that buffer. Its `buf_busy` bit falls only when the count reaches zero.
- R9: A completion that names a buffer with no outstanding commands is ignored. It does not make the buffer look busy or unavailable.
- R10: If the previous write's buffer has fully drained, a following write from the same source is treated as a fresh allocation under R2, with `grant_shared` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A WRITE command requests a buffer |
| req_src | input | SRC_W | Source ID of the requesting WRITE |
| req_ready | output | 1 | The request can be accepted this cycle |
| grant_valid | output | 1 | Registered one-cycle grant pulse |
| grant_buf | output | $clog2(NBUF) | Buffer index chosen for the accepted write |
| grant_shared | output | 1 | The write joins a buffer that already has queued commands |
| done_valid | input | 1 | One command has drained from a buffer |
| done_buf | input | $clog2(NBUF) | Index of the buffer that drained a command |
| buf_busy | output | NBUF | Per-buffer flag: outstanding count is non-zero |

## Verification
The embedded properties check several rules on every cycle. A buffer is never pushed past its count limit. The grant follows a stalled request is never issued. A granted buffer is busy once the grant appears. The shared flag agrees with whether the buffer was busy before the grant. The picker returns the lowest free index. Only the directed scenarios can show the allocation order itself. These include the choice between sticky reuse and a fresh buffer across interleaved sources, the end of stickiness once a buffer drains, stalls when all buffers are full or when the target count is saturated, and completions aimed at idle buffers.

// File: rtl/wba_pkg.sv
package wba_pkg;
  typedef enum logic {
    SEL_FREE   = 1'b0,
    SEL_STICKY = 1'b1
  } sel_e;
endpackage

// File: rtl/wba_pick.sv
module wba_pick #(
  parameter int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     free_vec,
  output logic             any_free,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) idx = IDX_W'(i);
    end
  end

  assign any_free = |free_vec;

  // R2: chosen index is free and nothing below it is free
  always_comb begin
    if (any_free) begin
      a_r2_lowest_free: assert (free_vec[idx] && ((free_vec & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/wba_slot.sv
module wba_slot #(
  parameter int SRC_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [SRC_W-1:0] src_in,
  output logic             busy,
  output logic             full,
  output logic [SRC_W-1:0] owner
);
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             dec_ok;

  assign dec_ok = dec && (cnt != '0);
  assign busy   = (cnt != '0);
  assign full   = (cnt == '1);

  always_comb begin
    cnt_nx = cnt;
    if (inc && !dec_ok)      cnt_nx = cnt + CNT_W'(1);
    else if (!inc && dec_ok) cnt_nx = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      owner <= '0;
    end else begin
      cnt <= cnt_nx;
      if (inc && !busy)        owner <= src_in;
      else if (cnt_nx == '0)   owner <= '0;
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) inc |-> !full);
  a_r9_idle_done_keeps_idle: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !busy) |=> !busy);
endmodule

// File: rtl/wba_alloc.sv
module wba_alloc #(
  parameter int NBUF  = 8,
  parameter int SRC_W = 4,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SRC_W-1:0] req_src,
  output logic             req_ready,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_buf,
  output logic             grant_shared,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_buf,
  output logic [NBUF-1:0]  buf_busy
);
  import wba_pkg::*;

  logic [NBUF-1:0]  full_vec;
  logic [NBUF-1:0]  inc_vec;
  logic [NBUF-1:0]  dec_vec;
  logic [SRC_W-1:0] owner_arr [NBUF];
  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic             last_vld;
  logic [IDX_W-1:0] last_buf;
  logic             accept;
  sel_e             sel;
  logic [IDX_W-1:0] tgt;

  wba_pick #(.N(NBUF)) u_pick (
    .free_vec (~buf_busy),
    .any_free (any_free),
    .idx      (free_idx)
  );

  always_comb begin
    sel = SEL_FREE;
    if (last_vld && buf_busy[last_buf] && (owner_arr[last_buf] == req_src))
      sel = SEL_STICKY;
  end

  assign tgt       = (sel == SEL_STICKY) ? last_buf : free_idx;
  assign req_ready = (sel == SEL_STICKY) ? !full_vec[last_buf] : any_free;
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    assign inc_vec[g] = accept && (tgt == IDX_W'(g));
    assign dec_vec[g] = done_valid && (done_buf == IDX_W'(g));
    wba_slot #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc_vec[g]),
      .dec    (dec_vec[g]),
      .src_in (req_src),
      .busy   (buf_busy[g]),
      .full   (full_vec[g]),
      .owner  (owner_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_vld     <= 1'b0;
      last_buf     <= '0;
      grant_valid  <= 1'b0;
      grant_buf    <= '0;
      grant_shared <= 1'b0;
    end else begin
      grant_valid <= accept;
      if (accept) begin
        last_vld     <= 1'b1;
        last_buf     <= tgt;
        grant_buf    <= tgt;
        grant_shared <= (sel == SEL_STICKY);
      end
    end
  end

  // R7: a refused request produces no grant
  a_r7_no_grant_on_stall: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !grant_valid);
  // R8: a granted buffer is outstanding when the grant appears
  a_r8_grant_buf_busy: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> buf_busy[grant_buf]);
  // R3: shared grants land on a buffer that was already busy
  a_r3_shared_was_busy: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_shared) |-> ((($past(buf_busy) >> grant_buf) & NBUF'(1)) != '0));
  // R2: fresh grants land on a buffer that was idle
  a_r2_fresh_was_idle: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !grant_shared) |-> ((($past(buf_busy) >> grant_buf) & NBUF'(1)) == '0));
  // R5: no request accepted, no grant
  a_r5_grant_needs_accept: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !grant_valid);
endmodule

// File: tb/wba_alloc_tb.sv
module wba_alloc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_src = '0;
  logic       req_ready;
  logic       grant_valid;
  logic [2:0] grant_buf;
  logic       grant_shared;
  logic       done_valid = 1'b0;
  logic [2:0] done_buf = '0;
  logic [7:0] buf_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  wba_alloc u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_ready(req_ready), .grant_valid(grant_valid), .grant_buf(grant_buf),
    .grant_shared(grant_shared), .done_valid(done_valid), .done_buf(done_buf),
    .buf_busy(buf_busy)
  );

  // Main table: source, expected buffer, expected shared flag
  localparam int NV = 11;
  localparam int V_SRC [NV] = '{1, 1, 2, 1, 1, 3, 4, 5, 6, 7, 7};
  localparam int V_BUF [NV] = '{0, 0, 1, 2, 2, 3, 4, 5, 6, 7, 7};
  localparam int V_SH  [NV] = '{0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic do_req(input int src, input int ebuf, input int esh, input string tag);
    req_valid = 1'b1;
    req_src   = 4'(src);
    #1 check(req_ready == 1'b1, {tag, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(grant_valid == 1'b1, {tag, " R5 grant_valid"}, int'(grant_valid), 1);
    check(int'(grant_buf) == ebuf, {tag, " buffer"}, int'(grant_buf), ebuf);
    check(int'(grant_shared) == esh, {tag, " shared"}, int'(grant_shared), esh);
  endtask

  task automatic do_done(input int b);
    done_valid = 1'b1;
    done_buf   = 3'(b);
    @(negedge clk);
    done_valid = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(buf_busy == 8'h00, "R1 busy after reset", int'(buf_busy), 0);
    check(grant_valid == 1'b0, "R1 no grant after reset", int'(grant_valid), 0);

    // Table walk: R2 lowest free, R3 sticky, R4 non-consecutive source
    for (int i = 0; i < NV; i++) begin
      do_req(V_SRC[i], V_BUF[i], V_SH[i], $sformatf("R2/R3/R4 vec%0d", i));
    end
    check(buf_busy == 8'hFF, "R8 all busy", int'(buf_busy), 255);

    // R7: all busy, new source stalls
    req_valid = 1'b1;
    req_src   = 4'd8;
    for (int k = 0; k < 3; k++) begin
      #1 check(req_ready == 1'b0, "R7 stall ready", int'(req_ready), 0);
      @(negedge clk);
      #1 check(grant_valid == 1'b0, "R7 no grant", int'(grant_valid), 0);
    end
    req_valid = 1'b0;

    // R8: single-command buffer releases
    do_done(3);
    check(buf_busy == 8'hF7, "R8 release buf3", int'(buf_busy), 247);
    // R9: completion on idle buffer ignored
    do_done(3);
    check(buf_busy == 8'hF7, "R9 idle done", int'(buf_busy), 247);
    do_req(9, 3, 0, "R9 buf3 usable");
    do_req(9, 3, 1, "R3 sticky buf3");
    do_done(3);
    check(buf_busy[3] == 1'b1, "R8 partial drain", int'(buf_busy[3]), 1);
    do_done(0);
    do_done(0);
    do_done(3);
    check(buf_busy == 8'hF6, "R8 buf0 buf3 released", int'(buf_busy), 246);
    // R10: previous buffer drained, same source gets lowest free
    do_req(9, 0, 0, "R10 fresh after drain");

    // R1 again, then R6 saturation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(buf_busy == 8'h00, "R1 busy after second reset", int'(buf_busy), 0);
    do_req(1, 0, 0, "R6 fill first");
    for (int k = 1; k < 15; k++) do_req(1, 0, 1, "R6 fill");
    req_valid = 1'b1;
    req_src   = 4'd1;
    #1 check(req_ready == 1'b0, "R6 saturated stall", int'(req_ready), 0);
    done_valid = 1'b1;
    done_buf   = 3'd0;
    @(negedge clk);
    done_valid = 1'b0;
    #1;
    check(grant_valid == 1'b0, "R6 no grant while full", int'(grant_valid), 0);
    check(req_ready == 1'b1, "R6 ready after drain", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(grant_valid == 1'b1 && grant_buf == 3'd0 && grant_shared,
          "R6 sticky grant after drain", int'(grant_buf), 0);
    @(negedge clk);
    #1 check(grant_valid == 1'b0, "R5 single pulse", int'(grant_valid), 0);

    finish_run();
  end
endmodule